// File: doc/BRIEF.md
# Ten-Bit LSB-First Serializer with Internal Wrap

This block turns pre-encoded 10-bit words into a serial bit stream. It runs on the bit-rate clock. A one-cycle byte strobe marks the moment the byte clock would rise. On that strobe the block captures the word on its parallel input and then sends it one bit per clock, starting with bit 0. The first bit of a word reaches the output a fixed number of bit times after the capture edge. That number is a parameter.

The stream always drives an internal wrap output, which the receive side can select for self-test. A loopback control picks where the external line output takes its value. When loopback is off, the line output carries the stream. When loopback is on, the line output is held at logic 1. Between words, during reset and before the first word, both outputs idle at logic 1.

Top module: `ser10_lsb_tx`

## Requirements
- R1: A word is captured only on a clock edge where `byte_stb` is 1. Changes on `tx_word` at any other time do not affect the stream.
- R2: The captured word leaves bit 0 first and bit 9 last. Bit i of the word is sent i bit times after bit 0.
- R3: Each word takes exactly ten bit clocks. With strobes every ten clocks, successive words form an unbroken stream with no idle bits between them.
- R4: If the capture happens at edge k, bit 0 is valid on the outputs from edge k+LAT_BITS (default 4) until edge k+LAT_BITS+1. Before that, the outputs still show the previous content.
- R5: With `loop_en` at 0, `line_out` equals the serial stream.
- R6: With `loop_en` at 1, `line_out` is held at 1 whatever the stream carries.
- R7: `wrap_out` carries the serial stream whatever the value of `loop_en`.
- R8: A strobe that comes before the current word has finished restarts the shift with the new word. The rest of the old word is dropped.
- R9: Both outputs read 1 in these cases: during reset, after reset and before the first strobe, and once a word has finished with no new strobe. A reset in the middle of a word discards that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_stb | input | 1 | One-cycle capture strobe, nominally once every ten clocks |
| tx_word | input | 10 | Pre-encoded word, bit 0 sent first |
| loop_en | input | 1 | 1 parks the line output at 1 |
| line_out | output | 1 | External serial output |
| wrap_out | output | 1 | Internal serial stream for the receive side |

## Verification
Each kind of internal error shows at the ports in its own way:
- A wrong bit count or a bad shift direction shows on `wrap_out` within one word. Bits come out reversed, a word is short or long, or idle ones appear in a continuous stream.
- A latency stage too many or too few shifts every bit by one position. This shows at the first bit of the first word, LAT_BITS cycles after its strobe.
- A strobe that does not restart the shifter leaves stale bits after an early strobe.
- A wrong idle or reset value shows at once as a 0 on either output while the stream is idle.

// File: rtl/ser_pkg.sv
// Shared constants for the serializer blocks.
package ser_pkg;
    // Level driven on the serial outputs when no word is in flight.
    localparam logic IDLE_LVL = 1'b1;
endpackage

// File: rtl/ser_word_shifter.sv
// Captures a word on a strobe and shifts it out one bit per clock,
// least significant bit first. Assumes WORD_W >= 2. An early strobe
// reloads the word. When no bits remain, the output idles at IDLE_LVL.
module ser_word_shifter
    import ser_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              bit_out
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  rem_q;

    // Load a new word on the strobe, otherwise move the next bit down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= {WORD_W{IDLE_LVL}};
            rem_q <= '0;
        end else if (load) begin
            sh_q  <= word_in;
            rem_q <= FULL_CNT;
        end else if (rem_q != '0) begin
            sh_q  <= {IDLE_LVL, sh_q[WORD_W-1:1]};
            rem_q <= rem_q - 1'b1;
        end
    end

    // Present the current bit while a word is in flight, else idle.
    assign bit_out = (rem_q != '0) ? sh_q[0] : IDLE_LVL;

    // R1: a strobe always arms a full word.
    a_r1_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rem_q == FULL_CNT);

    // R2: next bit comes from the next higher position.
    a_r2_lsb_order: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rem_q > 1) |=> sh_q[0] == $past(sh_q[1]));

    // R3: count never exceeds the word width.
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= FULL_CNT);

    // R9: with nothing left to send, the stream sits at idle.
    a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q == '0) |-> bit_out == IDLE_LVL);
endmodule

// File: rtl/ser_bit_delay.sv
// Fixed delay line of DEPTH registers on the serial stream. It sets the
// number of bit times from capture to the first bit. Assumes DEPTH >= 1.
// Resets to IDLE_LVL.
module ser_bit_delay
    import ser_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [DEPTH-1:0] pipe_q;

    generate
        if (DEPTH == 1) begin : g_single
            // Single stage: register the bit.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= {DEPTH{IDLE_LVL}};
                else        pipe_q <= d_in;
            end
        end else begin : g_chain
            // Multi stage: move every bit one stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= {DEPTH{IDLE_LVL}};
                else        pipe_q <= {pipe_q[DEPTH-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = pipe_q[DEPTH-1];
endmodule

// File: rtl/ser_line_select.sv
// Steers the delayed stream. The wrap output always carries it. The
// line output carries it unless loopback parks the line at IDLE_LVL.
module ser_line_select
    import ser_pkg::*;
(
    input  logic stream_in,
    input  logic loop_en,
    output logic line_out,
    output logic wrap_out
);
    // Route the stream to the line or park the line.
    always_comb begin
        line_out = loop_en ? IDLE_LVL : stream_in;
        wrap_out = stream_in;
    end
endmodule

// File: rtl/ser10_lsb_tx.sv
// Top level of the 10-bit serializer. The byte strobe stands in for the
// byte clock edge and is sampled in the bit clock domain. Assumes
// LAT_BITS >= 1 and input words already line-coded.
module ser10_lsb_tx #(
    parameter int WORD_W   = 10,
    parameter int LAT_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              loop_en,
    output logic              line_out,
    output logic              wrap_out
);
    logic shift_bit;
    logic delayed_bit;

    ser_word_shifter #(.WORD_W(WORD_W)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (byte_stb),
        .word_in (tx_word),
        .bit_out (shift_bit)
    );

    ser_bit_delay #(.DEPTH(LAT_BITS)) delay_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (shift_bit),
        .d_out (delayed_bit)
    );

    ser_line_select select_i (
        .stream_in (delayed_bit),
        .loop_en   (loop_en),
        .line_out  (line_out),
        .wrap_out  (wrap_out)
    );

    // R5: without loopback the line mirrors the wrapped stream.
    a_r5_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |-> line_out == wrap_out);

    // R6: with loopback the line is parked high.
    a_r6_line_parked: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> line_out);
endmodule

// File: tb/ser10_lsb_tx_tb_top.sv
// Self-checking bench. A model of the expected stream, indexed by clock
// edge, is checked against both outputs 1 ns after every rising edge.
module ser10_lsb_tx_tb_top;
    localparam int W   = 10;
    localparam int LAT = 4;
    localparam int EXP_N = 2048;
    localparam int NVEC = 12;
    // {loop, gap[4:0], word[9:0]}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {1'b0, 5'd10, 10'h17C}, {1'b0, 5'd10, 10'h283},
        {1'b0, 5'd10, 10'h2AA}, {1'b0, 5'd20, 10'h001},
        {1'b0, 5'd10, 10'h200}, {1'b0, 5'd6,  10'h0F0},
        {1'b0, 5'd10, 10'h3C5}, {1'b1, 5'd10, 10'h155},
        {1'b1, 5'd3,  10'h07C}, {1'b1, 5'd10, 10'h383},
        {1'b0, 5'd20, 10'h0AB}, {1'b0, 5'd10, 10'h3FE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_stb = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic loop_en = 1'b0;
    logic line_out, wrap_out;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    string tag = "R9";
    logic exp_bit [0:EXP_N-1];

    always #2.5 clk = ~clk;

    ser10_lsb_tx #(.WORD_W(W), .LAT_BITS(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .tx_word(tx_word),
        .loop_en(loop_en), .line_out(line_out), .wrap_out(wrap_out)
    );

    // Edge counter and per-cycle output check against the model.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        if (!done) begin
            checks++;
            if (wrap_out !== exp_bit[cyc]) begin
                errors++;
                $display("FAIL %s/R7 cycle %0d wrap_out=%b expected %b", tag, cyc, wrap_out, exp_bit[cyc]);
            end
            checks++;
            if (line_out !== (loop_en ? 1'b1 : exp_bit[cyc])) begin
                errors++;
                $display("FAIL %s cycle %0d line_out=%b expected %b", loop_en ? "R6" : "R5",
                         cyc, line_out, loop_en ? 1'b1 : exp_bit[cyc]);
            end
        end
    end

    // Drive one strobe at a falling edge and record its expected bits.
    task automatic send(input logic [W-1:0] w, input logic lp);
        int k;
        @(negedge clk);
        k = cyc + 1;
        byte_stb = 1'b1; tx_word = w; loop_en = lp;
        for (int i = 0; i < W; i++) exp_bit[k + LAT + i] = w[i];
        for (int i = W; i < W + LAT; i++) exp_bit[k + LAT + i] = 1'b1;
        @(negedge clk);
        byte_stb = 1'b0;
        tx_word = ~w;  // R1: ignored without a strobe
    endtask

    task automatic direct(input string t, input logic act, input logic ex);
        checks++;
        if (act !== ex) begin
            errors++;
            $display("FAIL %s actual %b expected %b", t, act, ex);
        end
    endtask

    initial begin
        for (int i = 0; i < EXP_N; i++) exp_bit[i] = 1'b1;
        repeat (4) @(negedge clk);
        direct("R9 reset line", line_out, 1'b1);
        direct("R9 reset wrap", wrap_out, 1'b1);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // Table walk: continuous, early (R8), idle gaps (R9), loopback (R6, R7).
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] e;
            e = VEC[v];
            tag = (e[14:10] < 5'd10) ? "R8" : (e[14:10] > 5'd10) ? "R9" :
                  e[15] ? "R6" : "R2/R3";
            send(e[9:0], e[15]);
            repeat (int'(e[14:10]) - 2) @(negedge clk);
        end
        repeat (20) @(negedge clk);

        // R4: first bit exactly LAT edges after capture.
        begin
            int k;
            tag = "R4";
            @(negedge clk);
            k = cyc + 1;
            send(10'h3FE, 1'b0);
            while (cyc < k + LAT - 1) @(posedge clk);
            #1.5;
            direct("R4 before first bit", wrap_out, 1'b1);
            @(posedge clk); #1.5;
            direct("R4 first bit", wrap_out, 1'b0);
            @(posedge clk); #1.5;
            direct("R2 second bit", wrap_out, 1'b1);
        end
        repeat (20) @(negedge clk);

        // R1: word changes without a strobe leave the line idle.
        tag = "R1";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            tx_word = W'(i * 37);
        end
        repeat (6) @(negedge clk);

        // R9: reset in the middle of a word discards it.
        tag = "R9";
        send(10'h000, 1'b0);
        repeat (LAT + 1) @(negedge clk);
        rst_n = 1'b0;
        for (int i = 1; i < 40; i++) exp_bit[cyc + i] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule